// File: doc/BRIEF.md
# Byte-Loaded AES-128 Block Engine

This engine encrypts or decrypts one 128-bit block under a 128-bit key, following FIPS-197. A host writes the key one byte at a time through a key port and the data block one byte at a time through a state port. Each port has its own byte pointer, and that pointer wraps after sixteen accesses. A pulse on `start` launches the operation. The `decrypt` input is sampled on that pulse and selects the direction. The result replaces the block in the state memory, and the host reads it back a byte at a time through the same state pointer.

When the `xor_mode` input is high, each state byte that is written is combined by XOR with the byte already held at that position, so the port can mask or chain data before a run. An operation always takes a fixed number of clocks from start to result, whatever the direction. For decryption the engine first walks the key schedule forward to the final round key, then runs the inverse rounds while stepping the schedule backward. It stays idle for the remaining clocks of the window.

Top module: `aes_byte_engine`

## Requirements
- R1: Key bytes are taken in FIPS-197 input order. The first byte written after reset or start is the most significant byte of the key. The key pointer wraps, so a seventeenth key write overwrites byte 0.
- R2: With `xor_mode` low, a state write replaces the byte at the state pointer, and the pointer advances by one. A seventeenth write lands on byte 0 again.
- R3: With `xor_mode` high, a state write stores the XOR of the written byte and the byte already at that position.
- R4: `state_rdata` always shows the state byte at the state pointer. A `state_re` pulse advances the pointer, with wrap. An accepted start returns both the key pointer and the state pointer to byte 0.
- R5: With `decrypt` low at start, the state ends as the FIPS-197 ciphertext of the loaded block under the loaded key.
- R6: With `decrypt` high at start, the state ends as the FIPS-197 plaintext of the loaded block under the loaded key.
- R7: `busy` rises on the clock edge that accepts start and stays high for exactly LATENCY cycles (default 375). `ready` rises on the same edge on which `busy` falls. `busy` and `ready` are never high together.
- R8: `ready` stays set until the next accepted start or state write. Reads do not clear it.
- R9: While `busy` is high, key writes, state writes, state reads and further start pulses have no effect on the key, the state, the pointers or the result.
- R10: When start and a state write arrive in the same cycle, start wins. The write is dropped and the state pointer restarts at byte 0.
- R11: After reset, `busy` and `ready` are low, and the state reads back as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_we | input | 1 | Key byte write strobe |
| key_wdata | input | 8 | Key byte to write |
| state_we | input | 1 | State byte write strobe |
| state_wdata | input | 8 | State byte to write |
| xor_mode | input | 1 | When high, state writes XOR into the stored byte |
| state_re | input | 1 | Advance the state pointer after a read |
| state_rdata | output | 8 | State byte at the state pointer |
| decrypt | input | 1 | Direction selected at start: 1 decrypt, 0 encrypt |
| start | input | 1 | Launch pulse |
| busy | output | 1 | Operation in progress |
| ready | output | 1 | Result available |

## Verification
Two things can land on the same edge: a start pulse and a state write. The bench provokes this by raising `start` and `state_we` in one cycle, with a stray byte on the data lines and a state pointer deliberately left off zero. It then judges the outcome from two observations. First, the read-back, starting at byte 0, must be the exact plaintext of the untouched ciphertext. Second, the run must still take the full latency. A second pairing is also covered: a read strobe arriving while `ready` is high must leave `ready` set, while a write must clear it.

// File: rtl/aes_eng_pkg.sv
package aes_eng_pkg;

  localparam int unsigned BLK_BYTES = 16;
  localparam int unsigned N_ROUNDS  = 10;

  typedef logic [127:0] block_t;

  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_halve(input logic [7:0] a);
    logic [7:0] t;
    t = a[0] ? (a ^ 8'h1b) : a;
    return {a[0], t[7:1]};
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] p;
    acc = 8'h00;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = gf_xtime(p);
    end
    return acc;
  endfunction

  // a^254 equals the multiplicative inverse; zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] p;
    r = 8'h01;
    p = a;
    for (int i = 1; i < 8; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
    logic [15:0] d;
    d = {x, x} << n;
    return d[15:8];
  endfunction

  function automatic logic [7:0] sub_byte(input logic [7:0] x);
    logic [7:0] b;
    b = gf_inv(x);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] inv_sub_byte(input logic [7:0] x);
    return gf_inv(rotl8(x, 1) ^ rotl8(x, 3) ^ rotl8(x, 6) ^ 8'h05);
  endfunction

  function automatic logic [31:0] sub_word(input logic [31:0] w);
    logic [31:0] o;
    for (int i = 0; i < 4; i++) o[31-8*i -: 8] = sub_byte(w[31-8*i -: 8]);
    return o;
  endfunction

  function automatic logic [31:0] rot_word(input logic [31:0] w);
    return {w[23:0], w[31:24]};
  endfunction

  function automatic logic [7:0] get_byte(input block_t blk, input int idx);
    return blk[127-8*idx -: 8];
  endfunction

  function automatic block_t put_byte(input block_t blk, input int idx, input logic [7:0] v);
    block_t o;
    o = blk;
    o[127-8*idx -: 8] = v;
    return o;
  endfunction

  // byte index = 4*column + row
  function automatic block_t shift_rows(input block_t s);
    block_t o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(4*c+r) -: 8] = s[127-8*(4*((c+r)%4)+r) -: 8];
    return o;
  endfunction

  function automatic block_t inv_shift_rows(input block_t s);
    block_t o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(4*c+r) -: 8] = s[127-8*(4*((c-r+4)%4)+r) -: 8];
    return o;
  endfunction

  function automatic logic [31:0] mix_col(input logic [31:0] w);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = w;
    return {gf_xtime(a0) ^ gf_xtime(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ gf_xtime(a1) ^ gf_xtime(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ gf_xtime(a2) ^ gf_xtime(a3) ^ a3,
            gf_xtime(a0) ^ a0 ^ a1 ^ a2 ^ gf_xtime(a3)};
  endfunction

  function automatic logic [31:0] inv_mix_col(input logic [31:0] w);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = w;
    return {gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09),
            gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0e) ^ gf_mul(a2, 8'h0b) ^ gf_mul(a3, 8'h0d),
            gf_mul(a0, 8'h0d) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0e) ^ gf_mul(a3, 8'h0b),
            gf_mul(a0, 8'h0b) ^ gf_mul(a1, 8'h0d) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0e)};
  endfunction

endpackage

// File: rtl/aes_key_step.sv
module aes_key_step
  import aes_eng_pkg::*;
(
  input  block_t     rk_in,
  input  logic [7:0] rcon_fwd,
  input  logic [7:0] rcon_bwd,
  output block_t     rk_fwd,
  output block_t     rk_bwd
);

  logic [31:0] w0, w1, w2, w3;
  logic [31:0] f0, f1, f2, f3;
  logic [31:0] b0, b1, b2, b3;
  logic [31:0] f_mix, b_mix;

  assign {w0, w1, w2, w3} = rk_in;

  // forward: next round key from current
  assign f_mix = sub_word(rot_word(w3)) ^ {rcon_fwd, 24'h000000};
  assign f0 = w0 ^ f_mix;
  assign f1 = w1 ^ f0;
  assign f2 = w2 ^ f1;
  assign f3 = w3 ^ f2;

  // backward: previous round key from current
  assign b3 = w3 ^ w2;
  assign b2 = w2 ^ w1;
  assign b1 = w1 ^ w0;
  assign b_mix = sub_word(rot_word(b3)) ^ {rcon_bwd, 24'h000000};
  assign b0 = w0 ^ b_mix;

  assign rk_fwd = {f0, f1, f2, f3};
  assign rk_bwd = {b0, b1, b2, b3};

endmodule

// File: rtl/aes_round_dp.sv
module aes_round_dp
  import aes_eng_pkg::*;
(
  input  block_t st_in,
  input  block_t rk,
  input  logic   op_dec,
  input  logic   last,
  output block_t st_out
);

  block_t subbed;
  block_t shifted;

  for (genvar b = 0; b < BLK_BYTES; b++) begin : g_sbox
    localparam int HI = 127 - 8*b;
    assign subbed[HI -: 8] = op_dec ? inv_sub_byte(st_in[HI -: 8]) : sub_byte(st_in[HI -: 8]);
  end

  // byte substitution and row rotation commute, so one order serves both
  assign shifted = op_dec ? inv_shift_rows(subbed) : shift_rows(subbed);

  for (genvar c = 0; c < 4; c++) begin : g_col
    localparam int HI = 127 - 32*c;
    logic [31:0] sh_c;
    logic [31:0] rk_c;
    logic [31:0] enc_c;
    logic [31:0] dec_t;
    logic [31:0] dec_c;
    assign sh_c  = shifted[HI -: 32];
    assign rk_c  = rk[HI -: 32];
    assign enc_c = (last ? sh_c : mix_col(sh_c)) ^ rk_c;
    assign dec_t = sh_c ^ rk_c;
    assign dec_c = last ? dec_t : inv_mix_col(dec_t);
    assign st_out[HI -: 32] = op_dec ? dec_c : enc_c;
  end

endmodule

// File: rtl/aes_seq.sv
module aes_seq #(
  parameter int unsigned LATENCY = 375,
  parameter int unsigned ROUNDS  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_go,
  input  logic start_dec,
  input  logic clr_ready,
  output logic busy,
  output logic ready,
  output logic op_dec,
  output logic ph_whiten,
  output logic ph_round,
  output logic ph_last,
  output logic ph_key_fwd,
  output logic ph_key_bwd,
  output logic done
);

  localparam int unsigned CW = (LATENCY > 2) ? $clog2(LATENCY) : 2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] base;

  // decryption spends ROUNDS steps walking the schedule forward first
  assign base       = op_dec ? CW'(ROUNDS) : '0;
  assign ph_whiten  = busy && (cnt == base);
  assign ph_round   = busy && (cnt > base) && (cnt <= base + CW'(ROUNDS));
  assign ph_last    = busy && (cnt == base + CW'(ROUNDS));
  assign ph_key_fwd = busy && (cnt < CW'(ROUNDS));
  assign ph_key_bwd = busy && op_dec && (cnt >= CW'(ROUNDS)) && (cnt < CW'(2*ROUNDS));
  assign done       = busy && (cnt == CW'(LATENCY-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      ready  <= 1'b0;
      op_dec <= 1'b0;
      cnt    <= '0;
    end else if (start_go) begin
      busy   <= 1'b1;
      ready  <= 1'b0;
      op_dec <= start_dec;
      cnt    <= '0;
    end else if (done) begin
      busy   <= 1'b0;
      ready  <= 1'b1;
    end else if (busy) begin
      cnt    <= cnt + 1'b1;
    end else if (clr_ready) begin
      ready  <= 1'b0;
    end
  end

endmodule

// File: rtl/aes_byte_engine.sv
module aes_byte_engine
  import aes_eng_pkg::*;
#(
  parameter int unsigned LATENCY = 375
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_we,
  input  logic [7:0] key_wdata,
  input  logic       state_we,
  input  logic [7:0] state_wdata,
  input  logic       xor_mode,
  input  logic       state_re,
  output logic [7:0] state_rdata,
  input  logic       decrypt,
  input  logic       start,
  output logic       busy,
  output logic       ready
);

  localparam int unsigned PTR_W = $clog2(BLK_BYTES);

  block_t            key_mem;
  block_t            st_mem;
  block_t            rk;
  logic [7:0]        rcon;
  logic [PTR_W-1:0]  key_ptr;
  logic [PTR_W-1:0]  st_ptr;

  // named events for the checker
  logic start_go, key_take, st_take, rd_take;
  logic op_dec, ph_whiten, ph_round, ph_last, ph_key_fwd, ph_key_bwd, done;
  logic [7:0] rcon_b;
  block_t rk_fwd, rk_bwd, round_out;

  assign start_go = start && !busy;
  assign key_take = key_we && !busy && !start_go;
  assign st_take  = state_we && !busy && !start_go;
  assign rd_take  = state_re && !busy && !start_go && !state_we;
  assign rcon_b   = gf_halve(rcon);

  assign state_rdata = get_byte(st_mem, int'(st_ptr));

  aes_seq #(.LATENCY(LATENCY), .ROUNDS(N_ROUNDS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_go   (start_go),
    .start_dec  (decrypt),
    .clr_ready  (st_take),
    .busy       (busy),
    .ready      (ready),
    .op_dec     (op_dec),
    .ph_whiten  (ph_whiten),
    .ph_round   (ph_round),
    .ph_last    (ph_last),
    .ph_key_fwd (ph_key_fwd),
    .ph_key_bwd (ph_key_bwd),
    .done       (done)
  );

  aes_key_step u_key (
    .rk_in    (rk),
    .rcon_fwd (rcon),
    .rcon_bwd (rcon_b),
    .rk_fwd   (rk_fwd),
    .rk_bwd   (rk_bwd)
  );

  aes_round_dp u_round (
    .st_in  (st_mem),
    .rk     (rk),
    .op_dec (op_dec),
    .last   (ph_last),
    .st_out (round_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_mem <= '0;
      st_mem  <= '0;
      rk      <= '0;
      rcon    <= 8'h00;
      key_ptr <= '0;
      st_ptr  <= '0;
    end else if (start_go) begin
      rk      <= key_mem;
      rcon    <= 8'h01;
      key_ptr <= '0;
      st_ptr  <= '0;
    end else begin
      if (key_take) begin
        key_mem <= put_byte(key_mem, int'(key_ptr), key_wdata);
        key_ptr <= key_ptr + 1'b1;
      end
      if (st_take) begin
        st_mem <= put_byte(st_mem, int'(st_ptr),
                           xor_mode ? (state_rdata ^ state_wdata) : state_wdata);
        st_ptr <= st_ptr + 1'b1;
      end else if (rd_take) begin
        st_ptr <= st_ptr + 1'b1;
      end else if (ph_whiten) begin
        st_mem <= st_mem ^ rk;
      end else if (ph_round) begin
        st_mem <= round_out;
      end
      if (ph_key_fwd) begin
        rk   <= rk_fwd;
        rcon <= gf_xtime(rcon);
      end else if (ph_key_bwd) begin
        rk   <= rk_bwd;
        rcon <= rcon_b;
      end
    end
  end

endmodule

// File: rtl/aes_engine_chk.sv
module aes_engine_chk #(
  parameter int unsigned LATENCY = 375
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         state_we,
  input logic         busy,
  input logic         ready,
  input logic         st_take,
  input logic [3:0]   st_ptr,
  input logic [127:0] key_mem
);

  localparam int unsigned LW = $clog2(LATENCY + 1) + 1;
  logic [LW-1:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == LW'(LATENCY)));

  // R7
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ready);

  // R7
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && ready));

  // R8
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start && !state_we) |=> ready);

  // R8
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && (start || state_we)) |=> !ready);

  // R9
  key_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(key_mem));

  // R9
  ptr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(st_ptr));

  // R10
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && state_we) |=> (st_ptr == 4'd0));

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_take |=> (st_ptr == 4'($past(st_ptr) + 4'd1)));

endmodule

bind aes_byte_engine aes_engine_chk #(.LATENCY(LATENCY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .state_we (state_we),
  .busy     (busy),
  .ready    (ready),
  .st_take  (st_take),
  .st_ptr   (st_ptr),
  .key_mem  (key_mem)
);

// File: tb/sim_aes_byte_engine.sv
`timescale 1ns/1ps
module sim_aes_byte_engine;

  localparam int unsigned LAT = 375;

  localparam logic [127:0] KEY_A = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] PT_A  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] CT_A  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] KEY_B = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] PT_B  = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] CT_B  = 128'h3925841d02dc09fbdc118597196a0b32;
  localparam logic [127:0] MASK  = 128'hdeadbeef0123456789abcdeff0e1d2c3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_we = 1'b0, state_we = 1'b0, state_re = 1'b0;
  logic xor_mode = 1'b0, decrypt = 1'b0, start = 1'b0;
  logic [7:0] key_wdata = 8'h00, state_wdata = 8'h00;
  logic [7:0] state_rdata;
  logic busy, ready;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  aes_byte_engine #(.LATENCY(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_wdata(key_wdata),
    .state_we(state_we), .state_wdata(state_wdata), .xor_mode(xor_mode),
    .state_re(state_re), .state_rdata(state_rdata), .decrypt(decrypt),
    .start(start), .busy(busy), .ready(ready)
  );

  function automatic logic [7:0] bsel(input logic [127:0] v, input int i);
    return v[127-8*i -: 8];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_key(input logic [127:0] k);
    for (int i = 0; i < 16; i++) begin
      key_we = 1'b1; key_wdata = bsel(k, i);
      @(negedge clk);
    end
    key_we = 1'b0;
  endtask

  task automatic put_state(input logic [127:0] s, input logic xr);
    xor_mode = xr;
    for (int i = 0; i < 16; i++) begin
      state_we = 1'b1; state_wdata = bsel(s, i);
      @(negedge clk);
    end
    state_we = 1'b0; xor_mode = 1'b0;
  endtask

  task automatic expect_state(input logic [127:0] exp, input string req);
    logic [127:0] got;
    state_re = 1'b1;
    for (int i = 0; i < 16; i++) begin
      got[127-8*i -: 8] = state_rdata;
      @(negedge clk);
    end
    state_re = 1'b0;
    chk(got == exp, req, got, exp);
  endtask

  // starts at a negedge; returns at the negedge after completion
  task automatic run_op(input logic dec, input logic noise, input logic collide);
    decrypt = dec; start = 1'b1;
    if (collide) begin state_we = 1'b1; state_wdata = 8'h5a; end
    @(negedge clk);
    start = 1'b0; state_we = 1'b0; decrypt = 1'b0;
    chk(busy === 1'b1 && ready === 1'b0, "R7 busy after start", {126'd0, busy, ready}, 128'd2);
    for (int j = 0; j < int'(LAT) - 1; j++) begin
      if (noise && j >= 5 && j < 12) begin
        key_we = 1'b1; key_wdata = 8'(j * 37);
        state_we = 1'b1; state_wdata = 8'(j * 11);
        state_re = 1'b1; start = (j == 8); decrypt = ~dec;
      end else begin
        key_we = 1'b0; state_we = 1'b0; state_re = 1'b0; start = 1'b0; decrypt = 1'b0;
      end
      @(negedge clk);
    end
    chk(busy === 1'b1 && ready === 1'b0, "R7 busy one cycle before end", {126'd0, busy, ready}, 128'd2);
    @(negedge clk);
    chk(busy === 1'b0 && ready === 1'b1, "R7 done at latency", {126'd0, busy, ready}, 128'd1);
  endtask

  task automatic t_reset;
    chk(busy === 1'b0 && ready === 1'b0, "R11 reset flags", {126'd0, busy, ready}, 128'd0);
    expect_state(128'd0, "R11 reset state");
  endtask

  task automatic t_encrypt_a;
    put_key(KEY_A);
    put_state(PT_A, 1'b0);
    expect_state(PT_A, "R2 R4 plain load readback");
    run_op(1'b0, 1'b0, 1'b0);
    expect_state(CT_A, "R5 encrypt vector A");
    chk(ready === 1'b1, "R8 reads keep ready", {127'd0, ready}, 128'd1);
  endtask

  task automatic t_decrypt_noise;
    run_op(1'b1, 1'b1, 1'b0);
    expect_state(PT_A, "R6 R9 decrypt vector A despite busy traffic");
  endtask

  task automatic t_xor_load;
    put_state(128'd0, 1'b0);
    chk(ready === 1'b0, "R8 write clears ready", {127'd0, ready}, 128'd0);
    put_state(MASK, 1'b1);
    expect_state(MASK, "R3 xor into zero");
    put_state(PT_B ^ MASK, 1'b1);
    expect_state(PT_B, "R3 xor cancels mask");
  endtask

  task automatic t_key_wrap;
    logic [127:0] junk;
    junk = KEY_B;
    junk[127:120] = 8'hee;
    put_key(junk);
    key_we = 1'b1; key_wdata = bsel(KEY_B, 0);
    @(negedge clk);
    key_we = 1'b0;
    run_op(1'b0, 1'b0, 1'b0);
    expect_state(CT_B, "R1 R5 key wrap then encrypt vector B");
  endtask

  task automatic t_collide;
    state_re = 1'b1;
    repeat (3) @(negedge clk);
    state_re = 1'b0;
    chk(state_rdata === bsel(CT_B, 3), "R4 pointer after three reads",
        {120'd0, state_rdata}, {120'd0, bsel(CT_B, 3)});
    run_op(1'b1, 1'b0, 1'b1);
    expect_state(PT_B, "R10 R4 start wins over write, pointer restarts");
  endtask

  task automatic t_state_wrap;
    logic [127:0] exp;
    for (int i = 0; i < 16; i++) exp[127-8*i -: 8] = 8'(8'h10 + i);
    put_state(exp, 1'b0);
    state_we = 1'b1; state_wdata = 8'hab;
    @(negedge clk);
    state_we = 1'b0;
    exp[127:120] = 8'hab;
    chk(state_rdata === 8'h11, "R2 pointer past wrapped byte",
        {120'd0, state_rdata}, 128'h11);
    state_re = 1'b1;
    repeat (15) @(negedge clk);
    state_re = 1'b0;
    expect_state(exp, "R2 seventeenth write lands on byte 0");
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_encrypt_a;
    t_decrypt_noise;
    t_xor_load;
    t_key_wrap;
    t_collide;
    t_state_wrap;
    finish_run;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run;
  end

endmodule